// File: doc/BRIEF.md
# Supervised Input Conditioner

This block cleans up one field input that arrives over a long cable, such as a door contact, an exit push-button or an enclosure tamper switch. The raw level is first passed through a two-stage synchronizer. A debounce filter then accepts a new level only once it has held steady for a programmable number of cycles. Three audit counters record how noisy the line is: synchronized raw edges, accepted level changes, and short excursions that were thrown away.

A second, independent path watches the health of the wiring itself. The loop carries an end-of-line resistor, and its voltage reaches the block as a stream of ADC samples. Each sample is sorted into one of five resistance buckets. A hysteresis band around the bucket currently held keeps readings near a boundary from flipping the result back and forth. A new bucket is committed only after the same bucket has been seen on several samples in a row. Each commit raises a one-cycle strobe that carries a reason code, and the committed bucket index and its loop state stay on the outputs.

The ADC samples arrive on a valid/ready stream. `adc_ready` goes high on the first clock edge after reset and stays high, so the block never applies back-pressure. Every cycle with `adc_valid` and `adc_ready` both high consumes one sample. Control and status pins are plain levels.

Top module: `loop_input_cond`

## Requirements
- R1: `raw_in` passes through two synchronizer flops. Each change of the synchronized level increments `raw_edge_cnt`, and the new count is visible three clock edges after the input change is first sampled.
- R2: `deb_state` takes a new level only after the synchronized level has differed from it for `STABLE_CYC` consecutive cycles. At the edge that updates it, `deb_chg` pulses for one cycle and `deb_chg_cnt` increments.
- R3: An excursion of the synchronized level that returns before `STABLE_CYC` cycles leaves `deb_state` unchanged and increments `glitch_cnt` once, on the cycle it returns.
- R4: All three counters stop at their all-ones value instead of wrapping.
- R5: A `cnt_clr` pulse sets all three counters to zero at the next edge. The clear wins over any increment in the same cycle.
- R6: A sample v is sorted into a bucket using thresholds T1<T2<T3<T4: 0 for v<T1, 1 for T1<=v<T2, 2 for T2<=v<T3, 3 for T3<=v<T4, 4 for v>=T4. `sup_state` encodes bucket 2 as 0 (normal), bucket 4 as 1 (open), bucket 0 as 2 (short), and buckets 1 and 3 as 3 (abnormal).
- R7: A sample that lies within `HYST` counts below the committed bucket's lower bound, or within `HYST` counts above its upper bound, counts as the committed bucket.
- R8: The committed bucket changes only when `CONSEC` consecutive accepted samples have given the same bucket, and that bucket differs from the one currently committed. After reset the bucket is 2.
- R9: Each commit pulses `sup_rsn_vld` for one cycle, in the cycle in which the new bucket appears. `sup_rsn` then gives 1 for bucket 2, 2 for bucket 4, 3 for bucket 0, 4 for bucket 1 and 5 for bucket 3.
- R10: `adc_ready` is low during reset, then goes high and stays high. A sample presented while `adc_valid` is low has no effect on the committed bucket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | Unsynchronized field input level |
| cnt_clr | input | 1 | Clears the three audit counters |
| adc_valid | input | 1 | Loop sample stream valid |
| adc_ready | output | 1 | Loop sample stream ready |
| adc_data | input | ADC_W | Loop sample value |
| deb_state | output | 1 | Debounced input level |
| deb_chg | output | 1 | One-cycle strobe on an accepted change |
| raw_edge_cnt | output | CNT_W | Synchronized raw edge count |
| deb_chg_cnt | output | CNT_W | Accepted change count |
| glitch_cnt | output | CNT_W | Rejected excursion count |
| sup_state | output | 2 | Loop supervision state |
| sup_bucket | output | 3 | Committed bucket index |
| sup_rsn_vld | output | 1 | One-cycle strobe on a supervision decision |
| sup_rsn | output | 3 | Reason code for the decision |

## Verification
Random pulse trains on the input mix hold times below, at and above the debounce length, so accepted changes and rejected excursions both occur, and exact-length directed pulses pin down the boundary between them. A one-cycle toggle train drives the counters into saturation, and toggles held during a clear show that the clear wins over an increment. Loop samples that land in each of the five buckets show how readings are sorted. Interrupted runs of matching samples show the consecutive-sample rule at work. Readings just inside and just outside the hysteresis band show the band's effect, and samples with valid held low check that an unaccepted sample has no effect.

// File: rtl/loop_cond_pkg.sv
package loop_cond_pkg;

  typedef enum logic [1:0] {
    LOOP_NORMAL   = 2'd0,
    LOOP_OPEN     = 2'd1,
    LOOP_SHORT    = 2'd2,
    LOOP_ABNORMAL = 2'd3
  } loop_state_e;

  typedef enum logic [2:0] {
    RSN_NONE       = 3'd0,
    RSN_RESTORED   = 3'd1,
    RSN_OPEN       = 3'd2,
    RSN_SHORT      = 3'd3,
    RSN_LOW_DRIFT  = 3'd4,
    RSN_HIGH_DRIFT = 3'd5
  } loop_rsn_e;

  localparam logic [2:0] BKT_SHORT = 3'd0;
  localparam logic [2:0] BKT_LOW   = 3'd1;
  localparam logic [2:0] BKT_NORM  = 3'd2;
  localparam logic [2:0] BKT_HIGH  = 3'd3;
  localparam logic [2:0] BKT_OPEN  = 3'd4;

  function automatic loop_state_e state_of_bucket(input logic [2:0] b);
    case (b)
      BKT_NORM:  return LOOP_NORMAL;
      BKT_OPEN:  return LOOP_OPEN;
      BKT_SHORT: return LOOP_SHORT;
      default:   return LOOP_ABNORMAL;
    endcase
  endfunction

  function automatic loop_rsn_e reason_of_bucket(input logic [2:0] b);
    case (b)
      BKT_NORM:  return RSN_RESTORED;
      BKT_OPEN:  return RSN_OPEN;
      BKT_SHORT: return RSN_SHORT;
      BKT_LOW:   return RSN_LOW_DRIFT;
      BKT_HIGH:  return RSN_HIGH_DRIFT;
      default:   return RSN_NONE;
    endcase
  endfunction

endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int  STAGES   = 2,
  parameter bit  IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{IDLE_LVL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lic_debounce.sv
module lic_debounce #(
  parameter int STABLE_CYC = 16,
  parameter bit IDLE_LVL   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic deb,
  output logic chg,
  output logic edge_hit,
  output logic accept_hit,
  output logic glitch_hit
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic          lvl_d;
  logic [CW-1:0] run;

  assign edge_hit   = (lvl != lvl_d);
  assign accept_hit = (lvl != deb) && (run == CW'(STABLE_CYC - 1));
  assign glitch_hit = (lvl == deb) && (run != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d <= IDLE_LVL;
      deb   <= IDLE_LVL;
      run   <= '0;
      chg   <= 1'b0;
    end else begin
      lvl_d <= lvl;
      chg   <= accept_hit;
      if (accept_hit) begin
        deb <= lvl;
        run <= '0;
      end else if (lvl != deb) begin
        run <= run + 1'b1;
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/lic_sat_cnt.sv
module lic_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q <= '0;
    else if (clr)               q <= '0;
    else if (inc && (q != '1))  q <= q + 1'b1;
  end
endmodule

// File: rtl/lic_supervise.sv
module lic_supervise
  import loop_cond_pkg::*;
#(
  parameter int ADC_W  = 10,
  parameter int TH1    = 100,
  parameter int TH2    = 400,
  parameter int TH3    = 600,
  parameter int TH4    = 900,
  parameter int HYST   = 16,
  parameter int CONSEC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [ADC_W-1:0] smp,
  output logic [1:0]       state,
  output logic [2:0]       bucket,
  output logic             rsn_vld,
  output logic [2:0]       rsn
);
  localparam int EW = ADC_W + 2;
  localparam int RW = $clog2(CONSEC + 1);

  function automatic logic [EW-1:0] edge_at(input int b);
    case (b)
      0:       return '0;
      1:       return EW'(TH1);
      2:       return EW'(TH2);
      3:       return EW'(TH3);
      4:       return EW'(TH4);
      default: return EW'(1) << ADC_W;
    endcase
  endfunction

  logic [2:0]    com_q, cand_q, raw_bkt, eff_bkt;
  logic [RW-1:0] run_q, run_nxt;
  logic [EW-1:0] v_e, lo_e, lo_x, hi_x;
  loop_state_e   state_q;
  loop_rsn_e     rsn_q;
  logic          in_win;

  always_comb begin
    v_e = EW'(smp);
    if      (v_e < EW'(TH1)) raw_bkt = BKT_SHORT;
    else if (v_e < EW'(TH2)) raw_bkt = BKT_LOW;
    else if (v_e < EW'(TH3)) raw_bkt = BKT_NORM;
    else if (v_e < EW'(TH4)) raw_bkt = BKT_HIGH;
    else                     raw_bkt = BKT_OPEN;
    lo_e    = edge_at(int'(com_q));
    lo_x    = (lo_e > EW'(HYST)) ? lo_e - EW'(HYST) : '0;
    hi_x    = edge_at(int'(com_q) + 1) + EW'(HYST);
    in_win  = (v_e >= lo_x) && (v_e < hi_x);
    eff_bkt = in_win ? com_q : raw_bkt;
    if (eff_bkt != cand_q)                 run_nxt = RW'(1);
    else if (run_q == RW'(CONSEC))         run_nxt = run_q;
    else                                   run_nxt = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      com_q   <= BKT_NORM;
      cand_q  <= BKT_NORM;
      run_q   <= '0;
      state_q <= LOOP_NORMAL;
      rsn_q   <= RSN_NONE;
      rsn_vld <= 1'b0;
    end else begin
      rsn_vld <= 1'b0;
      if (smp_vld) begin
        cand_q <= eff_bkt;
        run_q  <= run_nxt;
        if ((run_nxt == RW'(CONSEC)) && (eff_bkt != com_q)) begin
          com_q   <= eff_bkt;
          state_q <= state_of_bucket(eff_bkt);
          rsn_q   <= reason_of_bucket(eff_bkt);
          rsn_vld <= 1'b1;
        end
      end
    end
  end

  assign state  = state_q;
  assign bucket = com_q;
  assign rsn    = rsn_q;
endmodule

// File: rtl/loop_input_cond.sv
module loop_input_cond #(
  parameter int ADC_W      = 10,
  parameter int CNT_W      = 16,
  parameter int STABLE_CYC = 16,
  parameter int CONSEC     = 4,
  parameter int TH1        = 100,
  parameter int TH2        = 400,
  parameter int TH3        = 600,
  parameter int TH4        = 900,
  parameter int HYST       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_in,
  input  logic             cnt_clr,
  input  logic             adc_valid,
  output logic             adc_ready,
  input  logic [ADC_W-1:0] adc_data,
  output logic             deb_state,
  output logic             deb_chg,
  output logic [CNT_W-1:0] raw_edge_cnt,
  output logic [CNT_W-1:0] deb_chg_cnt,
  output logic [CNT_W-1:0] glitch_cnt,
  output logic [1:0]       sup_state,
  output logic [2:0]       sup_bucket,
  output logic             sup_rsn_vld,
  output logic [2:0]       sup_rsn
);
  localparam int NCNT = 3;

  logic             lvl_sync;
  logic [NCNT-1:0]  inc_vec;
  logic [CNT_W-1:0] cnt_q [NCNT];
  logic             rdy_q;

  lic_sync #(.STAGES(2), .IDLE_LVL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(lvl_sync)
  );

  lic_debounce #(.STABLE_CYC(STABLE_CYC), .IDLE_LVL(1'b0)) u_deb (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync),
    .deb(deb_state), .chg(deb_chg),
    .edge_hit(inc_vec[0]), .accept_hit(inc_vec[1]), .glitch_hit(inc_vec[2])
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    lic_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(inc_vec[i]), .q(cnt_q[i])
    );
  end

  assign raw_edge_cnt = cnt_q[0];
  assign deb_chg_cnt  = cnt_q[1];
  assign glitch_cnt   = cnt_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign adc_ready = rdy_q;

  lic_supervise #(
    .ADC_W(ADC_W), .TH1(TH1), .TH2(TH2), .TH3(TH3), .TH4(TH4),
    .HYST(HYST), .CONSEC(CONSEC)
  ) u_sup (
    .clk(clk), .rst_n(rst_n),
    .smp_vld(adc_valid && rdy_q), .smp(adc_data),
    .state(sup_state), .bucket(sup_bucket),
    .rsn_vld(sup_rsn_vld), .rsn(sup_rsn)
  );
endmodule

// File: rtl/loop_input_cond_chk.sv
module loop_input_cond_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_clr,
  input logic             adc_ready,
  input logic             deb_state,
  input logic             deb_chg,
  input logic [CNT_W-1:0] raw_edge_cnt,
  input logic [CNT_W-1:0] deb_chg_cnt,
  input logic [CNT_W-1:0] glitch_cnt,
  input logic [2:0]       sup_bucket,
  input logic             sup_rsn_vld
);
  AST_CHG_FLIPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    deb_chg |-> (deb_state != $past(deb_state))); // R2

  AST_LEVEL_FLIP_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_state != $past(deb_state)) |-> deb_chg); // R2

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (raw_edge_cnt >= $past(raw_edge_cnt)) &&
                 (deb_chg_cnt >= $past(deb_chg_cnt)) &&
                 (glitch_cnt >= $past(glitch_cnt))); // R4

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (raw_edge_cnt == '0) && (deb_chg_cnt == '0) && (glitch_cnt == '0)); // R5

  AST_RSN_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sup_rsn_vld |-> (sup_bucket != $past(sup_bucket))); // R9

  AST_COMMIT_HAS_RSN: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_bucket != $past(sup_bucket)) |-> sup_rsn_vld); // R9

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ready |=> adc_ready); // R10
endmodule

bind loop_input_cond loop_input_cond_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .adc_ready(adc_ready),
  .deb_state(deb_state), .deb_chg(deb_chg),
  .raw_edge_cnt(raw_edge_cnt), .deb_chg_cnt(deb_chg_cnt), .glitch_cnt(glitch_cnt),
  .sup_bucket(sup_bucket), .sup_rsn_vld(sup_rsn_vld)
);

// File: tb/loop_input_cond_bench.sv
module loop_input_cond_bench;
  localparam int ADC_W  = 10;
  localparam int CNT_W  = 6;
  localparam int STABLE = 4;
  localparam int CONSEC = 3;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_in = 1'b0, cnt_clr = 1'b0, adc_valid = 1'b0;
  logic [ADC_W-1:0] adc_data = '0;
  logic adc_ready, deb_state, deb_chg, sup_rsn_vld;
  logic [CNT_W-1:0] raw_edge_cnt, deb_chg_cnt, glitch_cnt;
  logic [1:0] sup_state;
  logic [2:0] sup_bucket, sup_rsn;

  always #5 clk = ~clk;

  loop_input_cond #(.ADC_W(ADC_W), .CNT_W(CNT_W), .STABLE_CYC(STABLE), .CONSEC(CONSEC),
                    .TH1(100), .TH2(400), .TH3(600), .TH4(900), .HYST(16)) u_loop_input_cond (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .cnt_clr(cnt_clr),
    .adc_valid(adc_valid), .adc_ready(adc_ready), .adc_data(adc_data),
    .deb_state(deb_state), .deb_chg(deb_chg),
    .raw_edge_cnt(raw_edge_cnt), .deb_chg_cnt(deb_chg_cnt), .glitch_cnt(glitch_cnt),
    .sup_state(sup_state), .sup_bucket(sup_bucket),
    .sup_rsn_vld(sup_rsn_vld), .sup_rsn(sup_rsn)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // reference model state
  int m_s1, m_s2, m_s2d, m_deb, m_run, m_chg;
  int m_raw, m_acc, m_gl;
  int m_com, m_cand, m_crun, m_rv, m_rsn, m_rdy;

  function automatic int edge_of(input int b);
    case (b) 0: return 0; 1: return 100; 2: return 400; 3: return 600; 4: return 900; default: return 1024; endcase
  endfunction
  function automatic int bkt_raw(input int v);
    return v < 100 ? 0 : v < 400 ? 1 : v < 600 ? 2 : v < 900 ? 3 : 4;
  endfunction
  function automatic int bkt_eff(input int v, input int com);
    int lo = edge_of(com) - 16;
    int hi = edge_of(com + 1) + 16;
    if (lo < 0) lo = 0;
    return (v >= lo && v < hi) ? com : bkt_raw(v);
  endfunction
  function automatic int state_of(input int b);
    case (b) 0: return 2; 2: return 0; 4: return 1; default: return 3; endcase
  endfunction
  function automatic int rsn_of(input int b);
    case (b) 0: return 3; 1: return 4; 2: return 1; 3: return 5; default: return 2; endcase
  endfunction
  function automatic int sat(input int c);
    return c >= CMAX ? CMAX : c + 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_s2d = 0; m_deb = 0; m_run = 0; m_chg = 0;
    m_raw = 0; m_acc = 0; m_gl = 0;
    m_com = 2; m_cand = 2; m_crun = 0; m_rv = 0; m_rsn = 0; m_rdy = 0;
  endtask

  task automatic model_step(input int r, input int c, input int av, input int ad);
    int e_inc = (m_s2 != m_s2d);
    int a_inc = 0, g_inc = 0;
    m_chg = 0;
    if (m_s2 != m_deb) begin
      if (m_run == STABLE - 1) begin a_inc = 1; m_deb = m_s2; m_run = 0; m_chg = 1; end
      else m_run++;
    end else begin
      if (m_run != 0) g_inc = 1;
      m_run = 0;
    end
    if (c) begin m_raw = 0; m_acc = 0; m_gl = 0; end
    else begin
      if (e_inc) m_raw = sat(m_raw);
      if (a_inc) m_acc = sat(m_acc);
      if (g_inc) m_gl = sat(m_gl);
    end
    m_s2d = m_s2; m_s2 = m_s1; m_s1 = r;
    m_rv = 0;
    if (av && m_rdy) begin
      int e = bkt_eff(ad, m_com);
      if (e != m_cand) m_crun = 1;
      else if (m_crun < CONSEC) m_crun++;
      m_cand = e;
      if (m_crun == CONSEC && e != m_com) begin m_com = e; m_rv = 1; m_rsn = rsn_of(e); end
    end
    m_rdy = 1;
  endtask

  task automatic tick(input int r, input int c, input int av, input int ad);
    @(negedge clk);
    raw_in = r[0]; cnt_clr = c[0]; adc_valid = av[0]; adc_data = ADC_W'(ad);
    @(posedge clk);
    model_step(r, c, av, ad);
    #1;
    chk("R2 deb_state", deb_state, m_deb);
    chk("R2 deb_chg", deb_chg, m_chg);
    chk("R1 raw_edge_cnt", raw_edge_cnt, m_raw);
    chk("R2 deb_chg_cnt", deb_chg_cnt, m_acc);
    chk("R3 glitch_cnt", glitch_cnt, m_gl);
    chk("R8 sup_bucket", sup_bucket, m_com);
    chk("R6 sup_state", sup_state, state_of(m_com));
    chk("R9 sup_rsn_vld", sup_rsn_vld, m_rv);
    if (m_rv) chk("R9 sup_rsn", sup_rsn, m_rsn);
    chk("R10 adc_ready", adc_ready, 1);
  endtask

  task automatic hold(input int r, input int n);
    for (int i = 0; i < n; i++) tick(r, 0, 0, 0);
  endtask

  task automatic feed(input int v, input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 1, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1c0d));
    model_reset();
    repeat (4) @(posedge clk);
    #1;
    chk("R10 ready low in reset", adc_ready, 0);
    chk("R8 reset bucket", sup_bucket, 2);
    chk("R6 reset state normal", sup_state, 0);
    chk("R2 reset level", deb_state, 0);
    chk("R1 reset edge count", raw_edge_cnt, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3: three-cycle excursion rejected, R2: four-cycle level accepted
    tick(0, 1, 0, 0); hold(0, 4);
    hold(1, 3); hold(0, 8);
    chk("R3 short pulse rejected", glitch_cnt, 1);
    chk("R3 level unchanged", deb_state, 0);
    chk("R1 two edges", raw_edge_cnt, 2);
    hold(1, 4); hold(0, 8);
    chk("R2 two accepted changes", deb_chg_cnt, 2);
    chk("R1 four edges", raw_edge_cnt, 4);

    // R4: saturation with one-cycle toggles
    for (int i = 0; i < 140; i++) tick(i % 2, 0, 0, 0);
    chk("R4 edge count saturated", raw_edge_cnt, CMAX);
    chk("R4 glitch count saturated", glitch_cnt, CMAX);
    // R5: clear while toggling
    for (int i = 0; i < 3; i++) tick(i % 2, 1, 0, 0);
    chk("R5 edge count cleared", raw_edge_cnt, 0);
    chk("R5 glitch count cleared", glitch_cnt, 0);
    hold(0, 8);

    // R6 / R9: each bucket
    feed(50, 3);
    chk("R6 short bucket", sup_bucket, 0); chk("R6 short state", sup_state, 2);
    chk("R9 short reason", sup_rsn, 3);
    feed(1000, 3);
    chk("R6 open bucket", sup_bucket, 4); chk("R9 open reason", sup_rsn, 2);
    feed(250, 3);
    chk("R6 low bucket abnormal", sup_state, 3); chk("R9 low reason", sup_rsn, 4);
    feed(500, 3);
    chk("R6 back to normal", sup_bucket, 2); chk("R9 restored reason", sup_rsn, 1);

    // R8: interrupted run
    feed(50, 2); feed(500, 1); feed(50, 2);
    chk("R8 interrupted run keeps bucket", sup_bucket, 2);
    feed(500, 3);

    // R7: hysteresis band
    feed(610, 4);
    chk("R7 inside band stays normal", sup_bucket, 2);
    feed(620, 3);
    chk("R7 beyond band moves high", sup_bucket, 3);
    feed(590, 3);
    chk("R7 inside band stays high", sup_bucket, 3);
    feed(580, 3);
    chk("R7 beyond band returns", sup_bucket, 2);

    // R10: samples without valid ignored
    for (int i = 0; i < 5; i++) tick(0, 0, 0, 50);
    chk("R10 invalid samples ignored", sup_bucket, 2);

    // random mix
    for (int seg = 0; seg < 300; seg++) begin
      int r   = $urandom_range(1, 0);
      int len = $urandom_range(7, 1);
      int reg_ = $urandom_range(4, 0);
      int v   = edge_of(reg_) + $urandom_range(edge_of(reg_ + 1) - edge_of(reg_) - 1, 0);
      for (int k = 0; k < len; k++)
        tick(r, ($urandom_range(199, 0) == 0), ($urandom_range(9, 0) < 7), v);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule